// File: doc/BRIEF.md
# HMAC-SHA-256 Two-Pass Key Sequencer

This block sits in front of a SHA-256 hash engine and runs the two hash passes that a keyed message authentication code needs, using one engine for both. It holds a secret key of 128, 256 or 512 bits in sixteen 32-bit registers. On a start request it opens a first pass. That pass sends the key XORed with the inner pad byte as a full 512-bit block, then the caller's message words. The engine is told the message bit length plus one block. When the first digest comes back, the block opens a second pass. That pass sends the key XORed with the outer pad byte, then the eight first-pass digest words, with a fixed length of 768 bits. The second digest becomes the authentication tag.

With keyed mode off, the block passes the message words through to the engine unchanged and passes the caller's length through as given. No key words are sent. The single digest that comes back is the result. The engine does the padding and the arithmetic. This block only sequences words and lengths. Each pass opens with a one-cycle start strobe that carries the length, followed by exactly ceil(length/32) data words on a valid/ready stream. Eight digest words then return on a valid-only stream.

Top module: `hmac_two_pass_seq`

## Requirements
- R1: After reset, busy, done, engStart, engValid and cfgErr are 0 and tag is all zero.
- R2: With cfgHmacEn=0, a run issues one engStart with engLen equal to msgBitLen. It then streams exactly ceil(msgBitLen/32) words, equal to the msgData words in order. The 8 returned digest words form the tag.
- R3: With cfgHmacEn=1, the first pass streams 16 inner pad words and then the message words. Inner pad word i is the XOR of the key word i with 0x36363636. Key word i is the value written at keyWrIdx=i if i is below the key word count, and zero otherwise. Index 0 is the most significant word of the block.
- R4: In keyed mode, the first pass engLen equals msgBitLen + 512.
- R5: In keyed mode, a second engStart follows the first digest, with engLen = 768. It streams 16 outer pad words (key words XOR 0x5c5c5c5c), then the 8 first-pass digest words in the order they arrived.
- R6: cfgKeyLen selects the key length: 0 for 128 bits (4 words), 1 for 256 bits (8 words), 2 for 512 bits (16 words). In keyed mode, a start with cfgKeyLen=3 sets cfgErr and issues no engStart. cfgErr is cleared by the next accepted start.
- R7: With cfgKeySwap=1, each key word is byte-reversed before padding.
- R8: A zero msgBitLen sends no message words. The pass holds only the key block in keyed mode, and no words at all in pass-through mode.
- R9: done is a one-cycle pulse in the cycle after the final digest word is taken. tag then holds those 8 words, with the first word in tag[255:224]. tag changes at no other time.
- R10: While busy, key writes and start requests are ignored.
- R11: engStart is a single-cycle pulse, raised only while busy. The engine outputs are quiet while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keyWrEn | input | 1 | Key register write strobe |
| keyWrIdx | input | 4 | Key word index, 0 = most significant |
| keyWrData | input | 32 | Key word value |
| cfgHmacEn | input | 1 | 1 = keyed two-pass mode, 0 = pass-through |
| cfgKeySwap | input | 1 | Byte-reverse each key word |
| cfgKeyLen | input | 2 | Key length code (0/1/2 legal, 3 illegal) |
| start | input | 1 | Start request, sampled while idle |
| msgBitLen | input | 64 | Message length in bits, sampled at start |
| msgValid | input | 1 | Message word valid |
| msgData | input | 32 | Message word |
| msgReady | output | 1 | Message word accepted |
| engStart | output | 1 | Pass start strobe to the engine |
| engLen | output | 64 | Pass bit length, valid with engStart |
| engValid | output | 1 | Word valid toward engine |
| engData | output | 32 | Word toward engine |
| engReady | input | 1 | Engine accepts word |
| digValid | input | 1 | Digest word valid from engine |
| digData | input | 32 | Digest word from engine |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Tag ready pulse |
| tag | output | 256 | Final digest |
| cfgErr | output | 1 | Illegal key length requested |

## Verification
The hardest situation to reach from the ports is the second pass. That pass streams a digest the block captured from the engine, so its content depends on what the engine returned earlier. The bench uses a stub engine whose digest is a mixing function of every word and the length it saw. A wrong, missing or reordered word in either pass therefore changes what is re-injected and, in the end, the tag. A reference model in the bench predicts every word of both passes. Start requests and key writes are also issued in the middle of a keyed run, to show that the block ignores them while busy.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;
  localparam int WORD_W     = 32;
  localparam int KEY_WORDS  = 16;
  localparam int DIG_WORDS  = 8;
  localparam int IDX_W      = $clog2(KEY_WORDS);
  localparam int DIG_IDX_W  = $clog2(DIG_WORDS);
  localparam int TAG_W      = WORD_W * DIG_WORDS;
  localparam int BLOCK_BITS = WORD_W * KEY_WORDS;
  localparam int OUTER_BITS = BLOCK_BITS + TAG_W;
  localparam logic [1:0] KLEN_BAD = 2'd3;
  localparam logic [7:0] IPAD_BYTE = 8'h36;
  localparam logic [7:0] OPAD_BYTE = 8'h5c;

  typedef enum logic [1:0] {SRC_IPAD, SRC_OPAD, SRC_MSG, SRC_DIG} srcSel_e;
  typedef enum logic [1:0] {LEN_RAW, LEN_INNER, LEN_OUTER} lenSel_e;

  typedef struct packed {
    srcSel_e          src;
    logic [IDX_W-1:0] idx;
    lenSel_e          lenSel;
    logic             latchCfg;
    logic             capDig;
    logic             finalTag;
  } seqCtl_t;
endpackage

// File: rtl/hmac_seq_ctrl.sv
module hmac_seq_ctrl
  import hmac_seq_pkg::*;
#(
  parameter int LEN_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfgHmacEn,
  input  logic [1:0]       cfgKeyLen,
  input  logic [LEN_W-1:0] msgBitLen,
  input  logic             msgValid,
  input  logic             engReady,
  input  logic             digValid,
  output seqCtl_t          ctl,
  output logic             engStart,
  output logic             engValid,
  output logic             msgReady,
  output logic             busy,
  output logic             cfgErr,
  output logic             done
);
  typedef enum logic [3:0] {
    S_IDLE, S_GO1, S_KEYI, S_MSG, S_WAIT1, S_GO2, S_KEYO, S_DIG, S_WAIT2
  } state_e;

  localparam logic [LEN_W-1:0] KEY_LAST = LEN_W'(KEY_WORDS - 1);
  localparam logic [LEN_W-1:0] DIG_LAST = LEN_W'(DIG_WORDS - 1);

  state_e           state;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] wordsQ;
  logic             hmacQ;
  logic             xfer;
  logic             accept;
  logic [LEN_W-1:0] wordsIn;

  assign wordsIn = (msgBitLen >> 5) + LEN_W'(|msgBitLen[4:0]);
  assign accept  = (state == S_IDLE) && start && !(cfgHmacEn && cfgKeyLen == KLEN_BAD);
  assign busy    = (state != S_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.src      = SRC_MSG;
    ctl.idx      = cnt[IDX_W-1:0];
    ctl.lenSel   = hmacQ ? LEN_INNER : LEN_RAW;
    ctl.latchCfg = accept;
    engStart     = 1'b0;
    engValid     = 1'b0;
    unique case (state)
      S_GO1:  engStart = 1'b1;
      S_GO2:  begin engStart = 1'b1; ctl.lenSel = LEN_OUTER; end
      S_KEYI: begin engValid = 1'b1; ctl.src = SRC_IPAD; end
      S_KEYO: begin engValid = 1'b1; ctl.src = SRC_OPAD; end
      S_DIG:  begin engValid = 1'b1; ctl.src = SRC_DIG; end
      S_MSG:  engValid = msgValid;
      default: ;
    endcase
    msgReady     = (state == S_MSG) && engReady;
    ctl.capDig   = (state == S_WAIT1 || state == S_WAIT2) && digValid;
    ctl.finalTag = ctl.capDig && (cnt == DIG_LAST) &&
                   (state == S_WAIT2 || !hmacQ);
  end

  assign xfer = engValid && engReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      wordsQ <= '0;
      hmacQ  <= 1'b0;
      cfgErr <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (accept) begin
            cfgErr <= 1'b0;
            hmacQ  <= cfgHmacEn;
            wordsQ <= wordsIn;
            state  <= S_GO1;
          end else begin
            cfgErr <= 1'b1;
          end
        end
        S_GO1: begin
          cnt   <= '0;
          state <= hmacQ ? S_KEYI : ((wordsQ == '0) ? S_WAIT1 : S_MSG);
        end
        S_KEYI: if (xfer) begin
          if (cnt == KEY_LAST) begin
            cnt   <= '0;
            state <= (wordsQ == '0) ? S_WAIT1 : S_MSG;
          end else cnt <= cnt + 1'b1;
        end
        S_MSG: if (xfer) begin
          if (cnt == wordsQ - 1'b1) begin
            cnt   <= '0;
            state <= S_WAIT1;
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT1: if (digValid) begin
          if (cnt == DIG_LAST) begin
            cnt   <= '0;
            state <= hmacQ ? S_GO2 : S_IDLE;
            done  <= !hmacQ;
          end else cnt <= cnt + 1'b1;
        end
        S_GO2: begin
          cnt   <= '0;
          state <= S_KEYO;
        end
        S_KEYO: if (xfer) begin
          if (cnt == KEY_LAST) begin
            cnt   <= '0;
            state <= S_DIG;
          end else cnt <= cnt + 1'b1;
        end
        S_DIG: if (xfer) begin
          if (cnt == DIG_LAST) begin
            cnt   <= '0;
            state <= S_WAIT2;
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT2: if (digValid) begin
          if (cnt == DIG_LAST) begin
            cnt   <= '0;
            state <= S_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hmac_seq_dp.sv
module hmac_seq_dp
  import hmac_seq_pkg::*;
#(
  parameter int LEN_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCtl_t           ctl,
  input  logic              busy,
  input  logic              keyWrEn,
  input  logic [IDX_W-1:0]  keyWrIdx,
  input  logic [WORD_W-1:0] keyWrData,
  input  logic              cfgKeySwap,
  input  logic [1:0]        cfgKeyLen,
  input  logic [LEN_W-1:0]  msgBitLen,
  input  logic [WORD_W-1:0] msgData,
  input  logic [WORD_W-1:0] digData,
  output logic [WORD_W-1:0] engData,
  output logic [LEN_W-1:0]  engLen,
  output logic [TAG_W-1:0]  tag
);
  localparam int BYTES = WORD_W / 8;

  logic [WORD_W-1:0] keyMem [KEY_WORDS];
  logic [WORD_W-1:0] digBuf [DIG_WORDS];
  logic              swapQ;
  logic [1:0]        klenQ;
  logic [LEN_W-1:0]  lenQ;
  logic [WORD_W-1:0] rawKey;
  logic [WORD_W-1:0] swapKey;
  logic [WORD_W-1:0] keyWord;
  logic [IDX_W:0]    keyCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_WORDS; i++) keyMem[i] <= '0;
    end else if (keyWrEn && !busy) begin
      keyMem[keyWrIdx] <= keyWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swapQ <= 1'b0;
      klenQ <= '0;
      lenQ  <= '0;
    end else if (ctl.latchCfg) begin
      swapQ <= cfgKeySwap;
      klenQ <= cfgKeyLen;
      lenQ  <= msgBitLen;
    end
  end

  assign rawKey = keyMem[ctl.idx];

  for (genvar b = 0; b < BYTES; b++) begin : gSwap
    assign swapKey[8*b +: 8] = swapQ ? rawKey[WORD_W-8-8*b +: 8] : rawKey[8*b +: 8];
  end

  assign keyCount = (IDX_W+1)'(4) << klenQ;
  assign keyWord  = ({1'b0, ctl.idx} < keyCount) ? swapKey : '0;

  always_comb begin
    unique case (ctl.src)
      SRC_IPAD: engData = keyWord ^ {BYTES{IPAD_BYTE}};
      SRC_OPAD: engData = keyWord ^ {BYTES{OPAD_BYTE}};
      SRC_DIG:  engData = digBuf[ctl.idx[DIG_IDX_W-1:0]];
      default:  engData = msgData;
    endcase
    unique case (ctl.lenSel)
      LEN_INNER: engLen = lenQ + LEN_W'(BLOCK_BITS);
      LEN_OUTER: engLen = LEN_W'(OUTER_BITS);
      default:   engLen = lenQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DIG_WORDS; j++) digBuf[j] <= '0;
    end else if (ctl.capDig) begin
      digBuf[ctl.idx[DIG_IDX_W-1:0]] <= digData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag <= '0;
    end else if (ctl.finalTag) begin
      for (int j = 0; j < DIG_WORDS - 1; j++) tag[TAG_W-1-WORD_W*j -: WORD_W] <= digBuf[j];
      tag[WORD_W-1:0] <= digData;
    end
  end
endmodule

// File: rtl/hmac_two_pass_seq.sv
module hmac_two_pass_seq
  import hmac_seq_pkg::*;
#(
  parameter int LEN_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keyWrEn,
  input  logic [IDX_W-1:0]  keyWrIdx,
  input  logic [WORD_W-1:0] keyWrData,
  input  logic              cfgHmacEn,
  input  logic              cfgKeySwap,
  input  logic [1:0]        cfgKeyLen,
  input  logic              start,
  input  logic [LEN_W-1:0]  msgBitLen,
  input  logic              msgValid,
  input  logic [WORD_W-1:0] msgData,
  output logic              msgReady,
  output logic              engStart,
  output logic [LEN_W-1:0]  engLen,
  output logic              engValid,
  output logic [WORD_W-1:0] engData,
  input  logic              engReady,
  input  logic              digValid,
  input  logic [WORD_W-1:0] digData,
  output logic              busy,
  output logic              done,
  output logic [TAG_W-1:0]  tag,
  output logic              cfgErr
);
  seqCtl_t ctl;

  hmac_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfgHmacEn(cfgHmacEn),
    .cfgKeyLen(cfgKeyLen), .msgBitLen(msgBitLen), .msgValid(msgValid),
    .engReady(engReady), .digValid(digValid), .ctl(ctl), .engStart(engStart),
    .engValid(engValid), .msgReady(msgReady), .busy(busy), .cfgErr(cfgErr),
    .done(done)
  );

  hmac_seq_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .busy(busy), .keyWrEn(keyWrEn),
    .keyWrIdx(keyWrIdx), .keyWrData(keyWrData), .cfgKeySwap(cfgKeySwap),
    .cfgKeyLen(cfgKeyLen), .msgBitLen(msgBitLen), .msgData(msgData),
    .digData(digData), .engData(engData), .engLen(engLen), .tag(tag)
  );
endmodule

// File: rtl/hmac_seq_chk.sv
module hmac_seq_chk
  import hmac_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             engStart,
  input logic             engValid,
  input logic             busy,
  input logic             cfgErr,
  input logic             done,
  input logic [TAG_W-1:0] tag
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) engStart |=> !engStart); // R11
  AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) engStart |-> busy); // R11
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!engValid && !engStart)); // R11
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_TAG_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(tag)); // R9
  AST_ERR_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) cfgErr |-> !busy); // R6
endmodule

bind hmac_two_pass_seq hmac_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .engStart(engStart), .engValid(engValid),
  .busy(busy), .cfgErr(cfgErr), .done(done), .tag(tag)
);

// File: tb/hmac_two_pass_seq_test.sv
`timescale 1ns/1ps
module hmac_two_pass_seq_test;
  logic clk = 0;
  logic rst_n = 0;
  logic keyWrEn = 0;
  logic [3:0] keyWrIdx = 0;
  logic [31:0] keyWrData = 0;
  logic cfgHmacEn = 0, cfgKeySwap = 0;
  logic [1:0] cfgKeyLen = 0;
  logic start = 0;
  logic [63:0] msgBitLen = 0;
  logic msgValid = 0;
  logic [31:0] msgData = 0;
  logic msgReady, engStart, engValid, busy, done, cfgErr;
  logic [63:0] engLen;
  logic [31:0] engData;
  logic engReady = 0, digValid = 0;
  logic [31:0] digData = 0;
  logic [255:0] tag;

  hmac_two_pass_seq uut (.*);

  always #10 clk = ~clk;

  int total = 0, failed = 0, starts = 0;
  logic [31:0] keyMdl [16];
  logic [63:0] expLen[$];
  string lenReq[$];
  logic [31:0] expWord[$];
  string wordReq[$];

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] hashStub(input logic [31:0] w[$], input logic [63:0] len);
    logic [255:0] h;
    logic [31:0] acc;
    h = '0;
    for (int j = 0; j < 8; j++) begin
      acc = len[31:0] ^ len[63:32] ^ (32'h9e3779b9 * 32'(j + 1));
      foreach (w[i]) acc = {acc[26:0], acc[31:27]} ^ (w[i] + 32'(i * j));
      h[255-32*j -: 32] = acc;
    end
    return h;
  endfunction

  function automatic logic [31:0] padWord(input int i, input logic [1:0] kl, input bit sw, input logic [7:0] pb);
    logic [31:0] k;
    k = keyMdl[i];
    if (sw) k = {k[7:0], k[15:8], k[23:16], k[31:24]};
    if (i >= (4 << kl)) k = '0;
    return k ^ {4{pb}};
  endfunction

  // stub engine with per-word comparison against the reference queues
  initial begin
    logic [31:0] got[$];
    logic [63:0] len;
    logic [255:0] h;
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      digValid = 0;
      engReady = 0;
      #1;
      if (engStart) begin
        starts++;
        len = engLen;
        if (expLen.size() == 0) check(0, "R11 unexpected engStart", 0, 0);
        else check(len == expLen[0], lenReq[0], len, expLen[0]);
        if (expLen.size() != 0) begin void'(expLen.pop_front()); void'(lenReq.pop_front()); end
        got.delete();
        while (got.size() < (len + 63'd31) / 32) begin
          @(negedge clk);
          engReady = (ph % 3 != 2);
          ph++;
          #1;
          if (engValid && engReady) begin
            got.push_back(engData);
            if (expWord.size() == 0) check(0, "R2 extra word", engData, 0);
            else begin
              check(engData == expWord[0], wordReq[0], engData, expWord[0]);
              void'(expWord.pop_front());
              void'(wordReq.pop_front());
            end
          end
        end
        h = hashStub(got, len);
        for (int j = 0; j < 8; j++) begin
          @(negedge clk);
          engReady = 0;
          digValid = 1;
          digData = h[255-32*j -: 32];
        end
      end
    end
  end

  task automatic writeKey(input int idx, input logic [31:0] val);
    @(negedge clk);
    keyWrEn = 1; keyWrIdx = 4'(idx); keyWrData = val;
    keyMdl[idx] = val;
    @(negedge clk);
    keyWrEn = 0;
  endtask

  task automatic runCase(input bit hm, input bit sw, input logic [1:0] kl, input logic [63:0] bits,
                         input bit poke, input string tagReq);
    logic [31:0] msg[$];
    logic [31:0] s1[$];
    logic [31:0] s2[$];
    logic [255:0] d1, expTag;
    int nW, idx, ph, wait_n;
    nW = int'((bits + 64'd31) / 32);
    for (int i = 0; i < nW; i++) msg.push_back((32'hA5000000 + 32'(i) * 32'h01030507) ^ bits[31:0]);
    if (hm) begin
      for (int i = 0; i < 16; i++) s1.push_back(padWord(i, kl, sw, 8'h36));
      foreach (msg[i]) s1.push_back(msg[i]);
      d1 = hashStub(s1, bits + 64'd512);
      for (int i = 0; i < 16; i++) s2.push_back(padWord(i, kl, sw, 8'h5c));
      for (int j = 0; j < 8; j++) s2.push_back(d1[255-32*j -: 32]);
      expLen.push_back(bits + 64'd512); lenReq.push_back("R4 first-pass length");
      expLen.push_back(64'd768);        lenReq.push_back("R5 second-pass length");
      for (int i = 0; i < 16; i++) begin expWord.push_back(s1[i]); wordReq.push_back(sw ? "R7 swapped inner pad" : "R3 inner pad word"); end
      for (int i = 16; i < s1.size(); i++) begin expWord.push_back(s1[i]); wordReq.push_back("R3 message word"); end
      foreach (s2[i]) begin expWord.push_back(s2[i]); wordReq.push_back("R5 outer pass word"); end
      expTag = hashStub(s2, 64'd768);
    end else begin
      expLen.push_back(bits); lenReq.push_back("R2 pass-through length");
      foreach (msg[i]) begin expWord.push_back(msg[i]); wordReq.push_back("R2 pass-through word"); end
      expTag = hashStub(msg, bits);
    end
    @(negedge clk);
    cfgHmacEn = hm; cfgKeySwap = sw; cfgKeyLen = kl; msgBitLen = bits; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      keyWrEn = 1; keyWrIdx = 0; keyWrData = 32'hDEADBEEF;
      start = 1; cfgHmacEn = ~hm; cfgKeySwap = ~sw; msgBitLen = 64'd4096;
      @(negedge clk);
      keyWrEn = 0; start = 0;
    end
    idx = 0; ph = 0;
    while (idx < nW) begin
      msgValid = (ph % 4 != 3);
      msgData = msg[idx];
      ph++;
      #1;
      if (msgValid && msgReady) idx++;
      @(negedge clk);
    end
    msgValid = 0;
    wait_n = 0;
    while (!done && wait_n < 3000) begin @(negedge clk); wait_n++; end
    check(done == 1'b1, "R9 done pulse", done, 1);
    check(tag == expTag, tagReq, tag, expTag);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", done, 0);
    check(expWord.size() == 0 && expLen.size() == 0, "R2 stream fully consumed", expWord.size(), 0);
    repeat (4) @(negedge clk);
    check(tag == expTag, "R9 tag held", tag, expTag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !engStart && !engValid && !cfgErr, "R1 idle after reset",
          {busy, done, engStart, engValid, cfgErr}, 0);
    check(tag == '0, "R1 tag zero", tag, 0);
    for (int i = 0; i < 16; i++) writeKey(i, 32'h01234567 * 32'(i + 3) ^ 32'h11223344);

    runCase(0, 0, 2'd0, 64'd80,  0, "R2 pass-through tag");
    runCase(0, 0, 2'd0, 64'd0,   0, "R8 empty pass-through tag");
    runCase(1, 0, 2'd1, 64'd150, 0, "R5 keyed tag 256-bit key");
    runCase(1, 1, 2'd0, 64'd64,  1, "R10 keyed tag with writes while busy");
    runCase(1, 0, 2'd2, 64'd0,   0, "R8 keyed empty message tag");

    s0 = starts;
    @(negedge clk);
    cfgHmacEn = 1; cfgKeyLen = 2'd3; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    check(cfgErr == 1'b1, "R6 illegal key length flagged", cfgErr, 1);
    check(busy == 1'b0 && starts == s0, "R6 no engine start", starts, s0);
    runCase(0, 0, 2'd3, 64'd33, 0, "R6 pass-through after error");
    check(cfgErr == 1'b0, "R6 error cleared by accepted start", cfgErr, 0);
    check(keyMdl[0] != 32'hDEADBEEF, "R10 key model untouched", keyMdl[0], 0);
    runCase(1, 1, 2'd2, 64'd200, 0, "R7 swapped 512-bit key tag");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule